// File: doc/BRIEF.md
# Oversampling Serial Receiver

This block recovers characters from an asynchronous serial line. An external rate generator supplies a one-cycle `sample_tick_i` strobe at 16 times the bit rate, or at 8 times the bit rate when double-speed operation is selected. The line passes through a reset-to-idle synchronizer. A falling edge on the idle-high line opens a frame. Every bit, the start bit included, is decided by a two-of-three vote over the centre samples of its bit period. A start bit that votes high is treated as noise and dropped.

Frame settings are captured when the start edge is seen and hold until that frame ends: speed, word length (5 to 9 bits), parity enable and parity sense. A finished word goes into a single holding register. It is presented together with its frame-error and parity-error flags until the consumer acknowledges it with `read_i`. An address-filter mode lets a node listening on a shared line discard data frames and accept only address frames.

Top module: `uart_rx_os`

## Requirements
- R1: After reset, `valid_o`, `frame_err_o`, `parity_err_o` and `overrun_o` are 0.
- R2: A frame begins on the first tick whose synchronized sample is low while the previous ticked sample was high. That sample counts as sample 1. In 16x mode every bit is decided from samples 8, 9 and 10 of its period, and the other samples have no effect.
- R3: With `double_speed_i`=1 at the start edge, a bit lasts 8 ticks and is decided from samples 4, 5 and 6.
- R4: A bit is the majority of its three vote samples, so one wrong vote sample does not change the bit.
- R5: If the start bit votes high, no word is produced. The receiver waits for a fresh high-to-low edge, and the next proper frame is received correctly.
- R6: Data arrives least-significant bit first. `data_len_i` gives the word length: values below 5 act as 5 and values above 9 act as 9. Bits of `data_o` above the word length read 0.
- R7: When parity was enabled at the start edge, a parity bit follows the data. It is even parity when `parity_odd_i`=0 and odd parity when it is 1. `parity_err_o` is 1 only when that bit disagrees, and is always 0 for frames received with parity disabled.
- R8: `frame_err_o` is 1 for a word whose first stop bit voted 0.
- R9: `valid_o` rises after a frame is accepted and stays high until a cycle with `read_i`=1. The flags `frame_err_o` and `parity_err_o` read 0 while `valid_o` is 0.
- R10: When a frame is accepted while `valid_o`=1 and `read_i`=0, `overrun_o` goes to 1 and the held word and flags are kept. `read_i` clears `overrun_o`.
- R11: With `addr_filter_i`=1, a frame whose type bit is 0 is discarded and changes no output. The type bit is data bit 8 for 9-bit words and the first stop bit otherwise. Frames with type bit 1 are accepted.
- R12: Changes to `double_speed_i`, `data_len_i`, `parity_en_i` or `parity_odd_i` after the start edge do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_tick_i | input | 1 | Oversampling strobe, one cycle wide |
| rx_i | input | 1 | Serial line, idle high |
| double_speed_i | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| data_len_i | input | 4 | Word length in bits, clamped to 5..9 |
| parity_en_i | input | 1 | Parity bit present and checked |
| parity_odd_i | input | 1 | 1 odd parity, 0 even parity |
| addr_filter_i | input | 1 | Discard frames whose type bit is 0 |
| read_i | input | 1 | Consume the held word |
| data_o | output | 9 | Received word, right-aligned |
| valid_o | output | 1 | Held word unread |
| frame_err_o | output | 1 | Held word had a zero stop bit |
| parity_err_o | output | 1 | Held word failed its parity check |
| overrun_o | output | 1 | A word was lost while the buffer was full |

## Verification
The bench drives line noise onto every sample outside the vote window. A receiver that samples off-centre or counts the start sample wrongly would then return corrupted words. It also flips a single vote sample, which catches a receiver that decides on one sample instead of a majority. A short start pulse that votes high must produce no word, and the following frame must still land intact; a receiver that ignores the vote would shift in garbage or lose alignment. The bench changes the configuration in the middle of a frame, fills the buffer twice without a read, and sends filtered frames of both type values. These cases expose unlatched settings, an overwritten older word, and a filter that reads the wrong type bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap0_i,
  input  logic cap1_i,
  input  logic smp_i,
  output logic vote_o
);
  import uart_rx_pkg::*;

  logic s0_q, s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= 1'b1;
      s1_q <= 1'b1;
    end else begin
      if (cap0_i) s0_q <= smp_i;
      if (cap1_i) s1_q <= smp_i;
    end
  end

  // third vote sample is the live one
  assign vote_o = maj3(s0_q, s1_q, smp_i);
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame #(
  parameter int unsigned OS_NORM  = 16,
  parameter int unsigned OS_FAST  = 8,
  parameter int unsigned DATA_MIN = 5,
  parameter int unsigned DATA_MAX = 9,
  parameter int unsigned LEN_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                rx_i,
  input  logic                ds_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  output logic                done_o,
  output logic [DATA_MAX-1:0] word_o,
  output logic                fe_o,
  output logic                pe_o,
  output logic                typ_o
);
  import uart_rx_pkg::*;

  localparam int unsigned CNT_W = $clog2(OS_NORM + 1);

  rx_state_e             state_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [LEN_W-1:0]      idx_q, n_q, len_clamp;
  logic [DATA_MAX-1:0]   word_q;
  logic                  last_q, ds_q, pen_q, odd_q, par_q;
  logic                  done_q, fe_q, pe_q, typ_q;
  logic [CNT_W-1:0]      os, mid, k;
  logic                  busy, cap0, cap1, decide, vote;

  assign len_clamp = (len_i < LEN_W'(DATA_MIN)) ? LEN_W'(DATA_MIN) :
                     (len_i > LEN_W'(DATA_MAX)) ? LEN_W'(DATA_MAX) : len_i;

  assign os     = ds_q ? CNT_W'(OS_FAST) : CNT_W'(OS_NORM);
  assign mid    = os >> 1;
  assign k      = (cnt_q == os) ? CNT_W'(1) : cnt_q + 1'b1;
  assign busy   = (state_q != ST_IDLE);
  assign cap0   = tick_i && busy && (k == mid);
  assign cap1   = tick_i && busy && (k == mid + CNT_W'(1));
  assign decide = tick_i && busy && (k == mid + CNT_W'(2));

  uart_rx_vote i_vote (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap0_i(cap0),
    .cap1_i(cap1),
    .smp_i (rx_i),
    .vote_o(vote)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      n_q     <= LEN_W'(DATA_MIN);
      word_q  <= '0;
      last_q  <= 1'b1;
      ds_q    <= 1'b0;
      pen_q   <= 1'b0;
      odd_q   <= 1'b0;
      par_q   <= 1'b0;
      done_q  <= 1'b0;
      fe_q    <= 1'b0;
      pe_q    <= 1'b0;
      typ_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        last_q <= rx_i;
        if (state_q == ST_IDLE) begin
          if (last_q && !rx_i) begin
            state_q <= ST_START;
            cnt_q   <= CNT_W'(1);
            ds_q    <= ds_i;
            n_q     <= len_clamp;
            pen_q   <= par_en_i;
            odd_q   <= par_odd_i;
            word_q  <= '0;
            par_q   <= 1'b0;
            pe_q    <= 1'b0;
            idx_q   <= '0;
          end
        end else begin
          cnt_q <= k;
          // new bit period begins
          if (k == CNT_W'(1)) begin
            case (state_q)
              ST_START: begin
                state_q <= ST_DATA;
                idx_q   <= '0;
              end
              ST_DATA: begin
                if (idx_q == n_q - 1'b1) state_q <= pen_q ? ST_PAR : ST_STOP;
                else                     idx_q   <= idx_q + 1'b1;
              end
              ST_PAR:  state_q <= ST_STOP;
              default: ;
            endcase
          end
          if (decide) begin
            case (state_q)
              ST_START: if (vote) state_q <= ST_IDLE;
              ST_DATA: begin
                word_q[idx_q] <= vote;
                par_q         <= par_q ^ vote;
              end
              ST_PAR:  pe_q <= (vote != (par_q ^ odd_q));
              ST_STOP: begin
                done_q  <= 1'b1;
                fe_q    <= !vote;
                typ_q   <= (n_q == LEN_W'(DATA_MAX)) ? word_q[DATA_MAX-1] : vote;
                state_q <= ST_IDLE;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  assign done_o = done_q;
  assign word_o = word_q;
  assign fe_o   = fe_q;
  assign pe_o   = pe_q;
  assign typ_o  = typ_q;
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int unsigned DATA_MAX = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                push_i,
  input  logic [DATA_MAX-1:0] word_i,
  input  logic                fe_i,
  input  logic                pe_i,
  input  logic                read_i,
  output logic [DATA_MAX-1:0] data_o,
  output logic                valid_o,
  output logic                fe_o,
  output logic                pe_o,
  output logic                ovr_o
);
  logic [DATA_MAX-1:0] data_q;
  logic                valid_q, fe_q, pe_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      fe_q    <= 1'b0;
      pe_q    <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (push_i) begin
      if (valid_q && !read_i) begin
        ovr_q <= 1'b1;  // older word wins
      end else begin
        data_q  <= word_i;
        valid_q <= 1'b1;
        fe_q    <= fe_i;
        pe_q    <= pe_i;
        ovr_q   <= 1'b0;
      end
    end else if (read_i) begin
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign fe_o    = valid_q & fe_q;
  assign pe_o    = valid_q & pe_q;
  assign ovr_o   = ovr_q;
endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os #(
  parameter int unsigned OS_NORM     = 16,
  parameter int unsigned OS_FAST     = 8,
  parameter int unsigned DATA_MIN    = 5,
  parameter int unsigned DATA_MAX    = 9,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LEN_W       = $clog2(DATA_MAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_tick_i,
  input  logic                rx_i,
  input  logic                double_speed_i,
  input  logic [LEN_W-1:0]    data_len_i,
  input  logic                parity_en_i,
  input  logic                parity_odd_i,
  input  logic                addr_filter_i,
  input  logic                read_i,
  output logic [DATA_MAX-1:0] data_o,
  output logic                valid_o,
  output logic                frame_err_o,
  output logic                parity_err_o,
  output logic                overrun_o
);
  logic                rx_s;
  logic                frm_done, frm_fe, frm_pe, frm_typ, frm_push;
  logic [DATA_MAX-1:0] frm_word;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  uart_rx_frame #(
    .OS_NORM (OS_NORM),
    .OS_FAST (OS_FAST),
    .DATA_MIN(DATA_MIN),
    .DATA_MAX(DATA_MAX),
    .LEN_W   (LEN_W)
  ) i_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (sample_tick_i),
    .rx_i     (rx_s),
    .ds_i     (double_speed_i),
    .len_i    (data_len_i),
    .par_en_i (parity_en_i),
    .par_odd_i(parity_odd_i),
    .done_o   (frm_done),
    .word_o   (frm_word),
    .fe_o     (frm_fe),
    .pe_o     (frm_pe),
    .typ_o    (frm_typ)
  );

  assign frm_push = frm_done && (!addr_filter_i || frm_typ);

  uart_rx_hold #(.DATA_MAX(DATA_MAX)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (frm_push),
    .word_i (frm_word),
    .fe_i   (frm_fe),
    .pe_i   (frm_pe),
    .read_i (read_i),
    .data_o (data_o),
    .valid_o(valid_o),
    .fe_o   (frame_err_o),
    .pe_o   (parity_err_o),
    .ovr_o  (overrun_o)
  );
endmodule

// File: rtl/uart_rx_os_chk.sv
module uart_rx_os_chk #(
  parameter int unsigned DATA_MAX = 9
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sample_tick_i,
  input logic                read_i,
  input logic [DATA_MAX-1:0] data_o,
  input logic                valid_o,
  input logic                overrun_o,
  input logic                done_i,
  input logic                push_i
);
  a_r2_done_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $past(sample_tick_i));

  a_r9_valid_from_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(push_i));

  a_r9_valid_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !read_i |=> valid_o);

  a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && read_i && !push_i |=> !valid_o);

  a_r10_data_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !read_i |=> $stable(data_o));

  a_r10_ovr_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> valid_o);
endmodule

bind uart_rx_os uart_rx_os_chk #(.DATA_MAX(DATA_MAX)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sample_tick_i(sample_tick_i),
  .read_i       (read_i),
  .data_o       (data_o),
  .valid_o      (valid_o),
  .overrun_o    (overrun_o),
  .done_i       (frm_done),
  .push_i       (frm_push)
);

// File: tb/test_uart_rx_os.sv
module test_uart_rx_os;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rx = 1'b1;
  logic       ds = 1'b0;
  logic [3:0] len = 4'd8;
  logic       pen = 1'b0;
  logic       podd = 1'b0;
  logic       filt = 1'b0;
  logic       rd = 1'b0;
  logic [8:0] data_o;
  logic       valid_o, fe_o, pe_o, ovr_o;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic       exp_valid = 1'b0, exp_fe = 1'b0, exp_pe = 1'b0, exp_ovr = 1'b0;
  logic [8:0] exp_data = '0;

  always #2 clk = ~clk;

  uart_rx_os i_uart_rx_os (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .sample_tick_i (tick),
    .rx_i          (rx),
    .double_speed_i(ds),
    .data_len_i    (len),
    .parity_en_i   (pen),
    .parity_odd_i  (podd),
    .addr_filter_i (filt),
    .read_i        (rd),
    .data_o        (data_o),
    .valid_o       (valid_o),
    .frame_err_o   (fe_o),
    .parity_err_o  (pe_o),
    .overrun_o     (ovr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " valid"}, 32'(valid_o), 32'(exp_valid));
    chk({tag, " frame_err"}, 32'(fe_o), 32'(exp_valid & exp_fe));
    chk({tag, " parity_err"}, 32'(pe_o), 32'(exp_valid & exp_pe));
    chk({tag, " overrun"}, 32'(ovr_o), 32'(exp_ovr));
    if (exp_valid) chk({tag, " data"}, 32'(data_o), 32'(exp_data));
  endtask

  function automatic int clamp_len(input int code);
    return (code < 5) ? 5 : (code > 9) ? 9 : code;
  endfunction

  // one oversample: line set at a falling edge, tick three clocks later
  task automatic samp(input logic v);
    rx = v;
    repeat (3) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic send_bit(input logic v, input int os, input int noise,
                          input bit is_stop, input bit is_start);
    int mid;
    int bad;
    mid = os / 2;
    bad = mid + int'($urandom_range(0, 2));
    for (int s = 1; s <= os; s++) begin
      logic x;
      x = v;
      if (noise == 1 && s == bad) x = ~v;
      if (noise == 2 && (s < mid || s > mid + 2) && !(is_start && s == 1) &&
          !(is_stop && s > mid + 2)) x = ~v;
      samp(x);
    end
  endtask

  task automatic do_read();
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    exp_valid = 1'b0;
    exp_ovr = 1'b0;
  endtask

  task automatic send_frame(input logic [8:0] word, input int len_code, input bit p_en,
                            input bit odd, input bit p_flip, input bit stop_v,
                            input bit dsp, input int noise, input bit scramble);
    int n;
    int os;
    logic p;
    logic typ;
    logic [8:0] w;
    n = clamp_len(len_code);
    os = dsp ? 8 : 16;
    w = word & 9'((1 << n) - 1);
    ds = dsp; len = 4'(len_code); pen = p_en; podd = odd;
    samp(1'b1);
    samp(1'b1);
    send_bit(1'b0, os, noise, 1'b0, 1'b1);
    if (scramble) begin
      ds = ~dsp; len = (n == 5) ? 4'd9 : 4'd5; pen = ~p_en; podd = ~odd;
    end
    p = 1'b0;
    for (int i = 0; i < n; i++) begin
      send_bit(w[i], os, noise, 1'b0, 1'b0);
      p = p ^ w[i];
    end
    if (p_en) send_bit(p ^ odd ^ p_flip, os, noise, 1'b0, 1'b0);
    send_bit(stop_v, os, noise, 1'b1, 1'b0);
    samp(1'b1);
    samp(1'b1);
    ds = dsp; len = 4'(len_code); pen = p_en; podd = odd;
    typ = (n == 9) ? w[8] : stop_v;
    if (!filt || typ) begin
      if (exp_valid) exp_ovr = 1'b1;
      else begin
        exp_valid = 1'b1;
        exp_data = w;
        exp_fe = !stop_v;
        exp_pe = p_en & p_flip;
        exp_ovr = 1'b0;
      end
    end
  endtask

  task automatic glitch(input bit dsp);
    int os;
    os = dsp ? 8 : 16;
    ds = dsp;
    samp(1'b1);
    samp(1'b1);
    for (int s = 1; s <= os; s++) samp(s <= os / 2 ? 1'b0 : 1'b1);
    samp(1'b1);
    samp(1'b1);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 after release");

    // R2 / R6: plain 8-bit frame, 16x
    send_frame(9'h0A5, 8, 0, 0, 0, 1, 0, 0, 0);
    check_all("R2 basic 16x");
    repeat (20) @(negedge clk);
    check_all("R9 still held");
    do_read();
    check_all("R9 read clears");

    // R3: 8x
    send_frame(9'h03C, 8, 0, 0, 0, 1, 1, 0, 0);
    check_all("R3 8x frame");
    do_read();
    send_frame(9'h0C3, 8, 0, 0, 0, 1, 1, 2, 0);
    check_all("R3 8x noise outside window");
    do_read();

    // R2: noise outside vote window, R4: one bad vote sample
    send_frame(9'h096, 8, 1, 0, 0, 1, 0, 2, 0);
    check_all("R2 noise outside window");
    do_read();
    send_frame(9'h169, 9, 1, 1, 0, 1, 0, 1, 0);
    check_all("R4 single bad vote sample");
    do_read();

    // R5: start glitch then clean frame
    glitch(0);
    check_all("R5 glitch no word");
    send_frame(9'h05A, 8, 0, 0, 0, 1, 0, 0, 0);
    check_all("R5 frame after glitch");
    do_read();
    glitch(1);
    send_frame(9'h011, 7, 0, 0, 0, 1, 1, 0, 0);
    check_all("R5 frame after 8x glitch");
    do_read();

    // R6: lengths and clamping
    send_frame(9'h1FF, 5, 0, 0, 0, 1, 0, 0, 0);
    check_all("R6 five bits");
    do_read();
    send_frame(9'h1A5, 9, 0, 0, 0, 1, 0, 0, 0);
    check_all("R6 nine bits");
    do_read();
    send_frame(9'h1F3, 2, 0, 0, 0, 1, 0, 0, 0);
    check_all("R6 clamp low");
    do_read();
    send_frame(9'h155, 15, 0, 0, 0, 1, 0, 0, 0);
    check_all("R6 clamp high");
    do_read();

    // R7: parity
    send_frame(9'h0B7, 8, 1, 0, 0, 1, 0, 0, 0);
    check_all("R7 even ok");
    do_read();
    send_frame(9'h0B7, 8, 1, 1, 0, 1, 0, 0, 0);
    check_all("R7 odd ok");
    do_read();
    send_frame(9'h012, 6, 1, 0, 1, 1, 0, 0, 0);
    check_all("R7 even error");
    do_read();
    send_frame(9'h1C4, 9, 1, 1, 1, 1, 1, 0, 0);
    check_all("R7 odd error");
    do_read();

    // R8: frame error
    send_frame(9'h07E, 8, 0, 0, 0, 0, 0, 0, 0);
    check_all("R8 stop low");
    do_read();

    // R10: overrun keeps older word
    send_frame(9'h0AA, 8, 0, 0, 0, 1, 0, 0, 0);
    send_frame(9'h055, 8, 1, 0, 1, 0, 0, 0, 0);
    check_all("R10 overrun");
    do_read();
    check_all("R10 read clears overrun");

    // R11: address filter
    filt = 1'b1;
    send_frame(9'h0F0, 8, 0, 0, 0, 0, 0, 0, 0);
    check_all("R11 data frame dropped");
    send_frame(9'h0F1, 8, 0, 0, 0, 1, 0, 0, 0);
    check_all("R11 address frame kept");
    do_read();
    send_frame(9'h0AB, 9, 0, 0, 0, 1, 0, 0, 0);
    check_all("R11 nine-bit type 0 dropped");
    send_frame(9'h1AB, 9, 0, 0, 0, 0, 0, 0, 0);
    check_all("R11 nine-bit type 1 kept");
    do_read();
    filt = 1'b0;

    // R12: settings changed mid-frame
    send_frame(9'h0D3, 8, 1, 0, 0, 1, 0, 0, 1);
    check_all("R12 scrambled parity frame");
    do_read();
    send_frame(9'h015, 5, 0, 1, 0, 1, 1, 0, 1);
    check_all("R12 scrambled 8x frame");
    do_read();

    // random mix
    for (int i = 0; i < 40; i++) begin
      if ($urandom_range(0, 9) < 6) do_read();
      filt = ($urandom_range(0, 4) == 0);
      send_frame(9'($urandom), int'($urandom_range(3, 11)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
                 ($urandom_range(0, 5) != 0), 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, 2)), 1'b0);
      check_all("R6 random frame");
    end
    filt = 1'b0;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule